// File: doc/BRIEF.md
# LED Matrix Row Scanner with Brightness Timing

This block lights a 20-column by 8-row LED array from a 160-bit dot image that has already been latched. It walks through the eight rows one after another. Each row gets a fixed slot of 64 display-clock cycles. Within that slot the row is lit for a number of cycles chosen by a 4-bit brightness code. The last four cycles of every slot are always dark.

The display clock comes from one of two sources: an internal oscillator tick, or an external oscillator tick. The external tick can optionally be divided by eight. A sleep bit stops the scan position and turns off every driver; the scan resumes from the same point when the bit is set again. A blank input forces all drivers off, but the scan keeps running. The two peak-current bits are passed out unchanged, so that an analog stage outside this block can use them.

Outputs are a one-hot row select and a 20-bit column enable. Both are registered.

Top module: `led_row_scanner`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `row_sel`, `col_en` and `peak_lvl` are all zero. Scanning starts at position 0, which is row 0, cycle 0.
- R2: When `use_ext` is 0, each `osc_tick` advances the display clock by one. When `use_ext` is 1 and `ext_div8` is 0, each `ext_tick` advances it by one.
- R3: When `use_ext` is 1 and `ext_div8` is 1, every eighth `ext_tick` advances the display clock. The divide counter is cleared whenever this mode is not active. `ext_div8` has no effect while `use_ext` is 0.
- R4: The scan position counts display-clock cycles modulo 512. The row is position/64 and the cycle within the slot is position mod 64. Rows are visited in the order 0 to 7, so any one row lights again 512 display cycles later.
- R5: The on-time is selected by `ctrl0[3:0]`. Codes 0 through 15 give these on-times in display cycles: 0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60. A row is lit in slot cycles 0 to on-time−1.
- R6: Slot cycles 60 to 63 are never lit, whatever the code.
- R7: While row r is lit, `col_en[c]` equals dot bit c*8+r. Column 0 is the leftmost column. `col_en` is zero whenever no row is lit.
- R8: Row 0 has no LEDs. Its slot still takes 64 cycles, but `row_sel[0]` is never driven high.
- R9: When `blank` is 1, `row_sel` and `col_en` are zero on the following clock. The scan position keeps advancing.
- R10: When `ctrl0[6]` is 0 (sleep), the scan position holds and all drivers are off. Setting the bit back to 1 resumes the scan from the held position.
- R11: `peak_lvl` follows `ctrl0[5:4]` one clock later.
- R12: `row_sel` and `col_en` are registered. On each clock they reflect the scan position, `ctrl0`, `blank` and the dots as they were just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| ext_tick | input | 1 | One-cycle pulse from the external oscillator |
| use_ext | input | 1 | 1 selects the external oscillator |
| ext_div8 | input | 1 | 1 divides the external tick by eight |
| ctrl0 | input | 7 | [6] awake, [5:4] peak level, [3:0] on-time code |
| blank | input | 1 | Forces all drivers off |
| dots | input | 160 | Latched dot image, bit c*8+r for column c, row r |
| row_sel | output | 8 | One-hot row drive |
| col_en | output | 20 | Column drive enables |
| peak_lvl | output | 2 | Peak-current code passed through |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it, including `peak_lvl`. A display tick at one edge advances the position. The new position is first visible at the next edge, and the divided external tick counts within the same cycle as the eighth `ext_tick`. The bench keeps a behavioural model that, at each rising edge, computes the expected outputs from its pre-edge position and the inputs held at that edge, and only then advances its own position. It compares against the design at the following falling edge, so every comparison falls in the cycle the result is due. Window counts of lit cycles start two clocks after a code change, which lets both the output register and the position settle.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  // on-time in display cycles for each 4-bit brightness code (non-linear)
  function automatic logic [5:0] on_cycles(input logic [3:0] code);
    logic [5:0] v;
    case (code)
      4'd0:  v = 6'd0;
      4'd1:  v = 6'd1;
      4'd2:  v = 6'd2;
      4'd3:  v = 6'd3;
      4'd4:  v = 6'd4;
      4'd5:  v = 6'd5;
      4'd6:  v = 6'd7;
      4'd7:  v = 6'd9;
      4'd8:  v = 6'd11;
      4'd9:  v = 6'd14;
      4'd10: v = 6'd18;
      4'd11: v = 6'd22;
      4'd12: v = 6'd28;
      4'd13: v = 6'd36;
      4'd14: v = 6'd48;
      default: v = 6'd60;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/disp_tick_gen.sv
module disp_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic ext_tick,
  input  logic use_ext,
  input  logic ext_div8,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_cnt;
  logic          div_on;

  assign div_on = use_ext && ext_div8;

  always_ff @(posedge clk) begin
    if (rst || !div_on) div_cnt <= '0;
    else if (ext_tick)  div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
  end

  always_comb begin
    if (!use_ext)       tick = osc_tick;
    else if (!ext_div8) tick = ext_tick;
    else                tick = ext_tick && (div_cnt == LAST);
  end

  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (div_on && tick) |=> (div_cnt == '0));
endmodule

// File: rtl/scan_pos_ctr.sv
module scan_pos_ctr #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             awake,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)                pos <= '0;
    else if (tick && awake) pos <= pos + 1'b1;
  end

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !awake |=> $stable(pos));
endmodule

// File: rtl/row_col_drv.sv
module row_col_drv #(
  parameter int COLS    = 20,
  parameter int ROWS    = 8,
  parameter int SLOT    = 64,
  parameter int DARK    = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int CYC_W  = $clog2(SLOT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROW_W-1:0]     row,
  input  logic [CYC_W-1:0]     cyc,
  input  logic [5:0]           on_time,
  input  logic                 awake,
  input  logic                 blank,
  input  logic [COLS*ROWS-1:0] dots,
  input  logic [1:0]           peak_in,
  output logic [ROWS-1:0]      row_sel,
  output logic [COLS-1:0]      col_en,
  output logic [1:0]           peak_lvl
);
  localparam int LIT_MAX = SLOT - DARK;

  logic            lit;
  logic [COLS-1:0] col_nxt;

  assign lit = awake && !blank && (row != '0)
            && (32'(cyc) < 32'(on_time)) && (32'(cyc) < LIT_MAX);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] grp;
    assign grp        = dots[c*ROWS +: ROWS];
    assign col_nxt[c] = lit && grp[row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel  <= '0;
      col_en   <= '0;
      peak_lvl <= '0;
    end else begin
      row_sel  <= lit ? (ROWS'(1) << row) : '0;
      col_en   <= col_nxt;
      peak_lvl <= peak_in;
    end
  end

  // R4
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  // R8
  row0_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !row_sel[0]);
  // R6
  tail_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(cyc) >= LIT_MAX) |=> (row_sel == '0));
  // R9
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> (row_sel == '0 && col_en == '0));
  // R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
    !awake |=> (row_sel == '0));
  // R7
  col_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (row_sel == '0) |-> (col_en == '0));
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner #(
  parameter int COLS    = 20,
  parameter int ROWS    = 8,
  parameter int SLOT    = 64,
  parameter int DARK    = 4,
  parameter int EXT_DIV = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 osc_tick,
  input  logic                 ext_tick,
  input  logic                 use_ext,
  input  logic                 ext_div8,
  input  logic [6:0]           ctrl0,
  input  logic                 blank,
  input  logic [COLS*ROWS-1:0] dots,
  output logic [ROWS-1:0]      row_sel,
  output logic [COLS-1:0]      col_en,
  output logic [1:0]           peak_lvl
);
  import led_scan_pkg::*;

  localparam int ROW_W = $clog2(ROWS);
  localparam int CYC_W = $clog2(SLOT);
  localparam int POS_W = ROW_W + CYC_W;

  logic             tick;
  logic [POS_W-1:0] pos;
  logic [5:0]       on_time;

  assign on_time = on_cycles(ctrl0[3:0]);

  disp_tick_gen #(.DIV(EXT_DIV)) u_tick (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .ext_tick(ext_tick),
    .use_ext(use_ext), .ext_div8(ext_div8), .tick(tick)
  );

  scan_pos_ctr #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .tick(tick), .awake(ctrl0[6]), .pos(pos)
  );

  row_col_drv #(.COLS(COLS), .ROWS(ROWS), .SLOT(SLOT), .DARK(DARK)) u_drv (
    .clk(clk), .rst(rst),
    .row(pos[POS_W-1:CYC_W]), .cyc(pos[CYC_W-1:0]),
    .on_time(on_time), .awake(ctrl0[6]), .blank(blank), .dots(dots),
    .peak_in(ctrl0[5:4]),
    .row_sel(row_sel), .col_en(col_en), .peak_lvl(peak_lvl)
  );
endmodule

// File: tb/led_row_scanner_tb_top.sv
module led_row_scanner_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         osc_tick = 1'b0, ext_tick = 1'b0, use_ext = 1'b0, ext_div8 = 1'b0;
  logic [6:0]   ctrl0 = '0;
  logic         blank = 1'b0;
  logic [159:0] dots = '0;
  logic [7:0]   row_sel;
  logic [19:0]  col_en;
  logic [1:0]   peak_lvl;

  int total = 0, bad = 0, cyc_n = 0;
  int osc_pat = 1, ext_pat = 0;   // 0 never, 1 always, 2 every third, 3 random
  string cur_tag = "R1";
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  led_row_scanner dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .ext_tick(ext_tick),
    .use_ext(use_ext), .ext_div8(ext_div8), .ctrl0(ctrl0), .blank(blank),
    .dots(dots), .row_sel(row_sel), .col_en(col_en), .peak_lvl(peak_lvl)
  );

  int tbl [16] = '{0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60};

  // behavioural reference
  int m_pos = 0, m_pre = 0;
  logic [7:0]  e_row = '0;
  logic [19:0] e_col = '0;
  logic [1:0]  e_pk  = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_pre = 0; e_row = '0; e_col = '0; e_pk = '0;
    end else begin
      int r, c, on;
      bit lit, t;
      r = m_pos / 64; c = m_pos % 64; on = tbl[ctrl0[3:0]];
      lit = ctrl0[6] && !blank && r != 0 && c < on && c < 60;
      e_row = lit ? 8'(1 << r) : 8'h0;
      for (int k = 0; k < 20; k++) e_col[k] = lit && dots[k*8 + r];
      e_pk = ctrl0[5:4];
      t = 1'b0;
      if (!use_ext) begin m_pre = 0; t = osc_tick; end
      else if (!ext_div8) begin m_pre = 0; t = ext_tick; end
      else if (ext_tick) begin
        if (m_pre == 7) begin m_pre = 0; t = 1'b1; end
        else m_pre = m_pre + 1;
      end
      if (t && ctrl0[6]) m_pos = (m_pos + 1) % 512;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // tick drivers and per-cycle comparison
  always @(negedge clk) begin
    cyc_n++;
    case (osc_pat)
      1: osc_tick = 1'b1;
      2: osc_tick = (cyc_n % 3 == 0);
      3: osc_tick = $urandom_range(1, 0) == 1;
      default: osc_tick = 1'b0;
    endcase
    case (ext_pat)
      1: ext_tick = 1'b1;
      2: ext_tick = (cyc_n % 3 == 0);
      3: ext_tick = $urandom_range(1, 0) == 1;
      default: ext_tick = 1'b0;
    endcase
    if (cmp_on) begin
      chk(row_sel == e_row, cur_tag, 64'(row_sel), 64'(e_row));
      chk(col_en  == e_col, cur_tag, 64'(col_en),  64'(e_col));
      chk(peak_lvl == e_pk, "R11",   64'(peak_lvl), 64'(e_pk));
    end
    if (cyc_n > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_lit(int bitn, int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (row_sel[bitn]) cnt++;
    end
  endtask

  initial begin
    int cnt, t0, t1;
    for (int w = 0; w < 5; w++) dots[w*32 +: 32] = $urandom;
    ctrl0 = 7'h4F;
    wait_n(3);
    // R1: reset state
    chk(row_sel == 0 && col_en == 0 && peak_lvl == 0, "R1", 64'(row_sel), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(row_sel == 0 && col_en == 0 && peak_lvl == 0, "R1", 64'(col_en), 0);
    cmp_on = 1'b1;

    // R4: frame period 512 with tick every cycle
    cur_tag = "R4";
    while (!row_sel[1]) @(negedge clk);
    t0 = cyc_n;
    while (row_sel[1]) @(negedge clk);
    while (!row_sel[1]) @(negedge clk);
    t1 = cyc_n;
    chk(t1 - t0 == 512, "R4", 64'(t1 - t0), 512);

    // R6: full code gives 60 lit cycles per slot, never more
    cur_tag = "R6";
    count_lit(3, 512, cnt);
    chk(cnt == 60, "R6", 64'(cnt), 60);

    // R7: new dot image, check columns each cycle
    cur_tag = "R7";
    dots = {40{4'hA}};
    wait_n(600);
    for (int w = 0; w < 5; w++) dots[w*32 +: 32] = $urandom;
    wait_n(600);

    // R5: sweep every code
    cur_tag = "R5";
    for (int code = 0; code < 16; code++) begin
      ctrl0 = {3'b100, 4'(code)};
      wait_n(2);
      count_lit(2, 512, cnt);
      chk(cnt == tbl[code], "R5", 64'(cnt), 64'(tbl[code]));
    end

    // R8: whole frame, row 0 never driven
    cur_tag = "R8";
    ctrl0 = 7'h4F;
    count_lit(0, 520, cnt);
    chk(cnt == 0, "R8", 64'(cnt), 0);

    // R2: internal sparse ticks, external ticks ignored, prescale ignored
    cur_tag = "R2";
    osc_pat = 2; ext_pat = 1; ext_div8 = 1'b1;
    wait_n(1600);
    // R3: prescale ignored on internal source
    cur_tag = "R3";
    osc_pat = 3; ext_pat = 3;
    wait_n(1600);
    // R2: external direct
    cur_tag = "R2";
    use_ext = 1'b1; ext_div8 = 1'b0; osc_pat = 1; ext_pat = 3;
    wait_n(1600);
    // R3: external divided by eight
    cur_tag = "R3";
    ext_div8 = 1'b1; ext_pat = 1; osc_pat = 0;
    wait_n(2);
    count_lit(5, 4096, cnt);
    chk(cnt == 60 * 8, "R3", 64'(cnt), 480);
    ext_pat = 3;
    wait_n(3000);
    ext_div8 = 1'b0;
    wait_n(300);
    ext_div8 = 1'b1;
    wait_n(3000);
    use_ext = 1'b0; ext_div8 = 1'b0; osc_pat = 1; ext_pat = 0;

    // R9: blanking
    cur_tag = "R9";
    blank = 1'b1;
    count_lit(4, 512, cnt);
    chk(cnt == 0, "R9", 64'(cnt), 0);
    for (int i = 0; i < 40; i++) begin
      blank = (i % 3 == 0);
      wait_n(17);
    end
    blank = 1'b0;

    // R10: sleep freezes and darkens, then resumes
    cur_tag = "R10";
    wait_n(200);
    ctrl0 = 7'h0F;
    count_lit(0, 1, cnt);
    chk(row_sel == 0 && col_en == 0, "R10", 64'(row_sel), 0);
    wait_n(300);
    ctrl0 = 7'h4F;
    wait_n(1200);

    // R11: peak code passthrough
    cur_tag = "R11";
    ctrl0 = 7'h6C;
    @(negedge clk); #1;
    chk(peak_lvl == 2'b10, "R11", 64'(peak_lvl), 2);
    ctrl0 = 7'h5C;
    @(negedge clk); #1;
    chk(peak_lvl == 2'b01, "R11", 64'(peak_lvl), 1);

    // R12: registered timing under mixed stimulus
    cur_tag = "R12";
    osc_pat = 3;
    for (int i = 0; i < 30; i++) begin
      ctrl0 = 7'($urandom) | 7'h40;
      blank = ($urandom_range(3, 0) == 0);
      dots[31:0] = $urandom;
      wait_n(50);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule